// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of a successive-approximation converter that sits on a microprocessor-style bus. A host starts a conversion by pulling chip select and write low together; while both stay low the search logic is held cleared. Once either strobe rises, the sequencer waits for the next terminal count of a free-running step divider. It then walks a single one from the top bit of the code to the bottom, one bit per step. For each bit it sets the trial bit, presents the trial code to an external DAC and comparator, and keeps or drops the bit according to the comparator's answer.

When the last bit has been decided, the finished word goes into an output latch and the active-low done interrupt falls. The host reads the word by pulling chip select and read low; that enables the data outputs and clears the interrupt. If the interrupt output is wired back to the write strobe while chip select is held low, the block converts continuously on its own.

The comparator input `cmp_ge` is taken as valid in the same cycle as `dac_code`. It is high when the analog input is at or above the level of the code on display.

Top module: `sar_seq_top`

## Requirements
- R1: While `cs_n` and `wr_n` are both low at a clock edge, the clock after that edge shows `int_n` = 1 and `dac_code` = 0, and no search is in progress.
- R2: After the strobes release, the first trial code 8'h80 appears on `dac_code` at the first terminal count of the divide-by-`STEP_CLKS` phase counter, which is 1 to 8 clocks after release.
- R3: The search is MSB first. `dac_code` shows the bits decided so far OR'ed with the current trial bit. It changes only at step boundaries or on a hold. A trial bit is kept when `cmp_ge` = 1 at the step's terminal count.
- R4: The clock after the LSB decision, the output latch takes the finished code and `int_n` falls. That is 65 clocks after the first trial code appears.
- R5: Once low, `int_n` stays low until the clock after `cs_n` = 0 with `rd_n` = 0 (read) or with `wr_n` = 0 (hold). When completion and a read land on the same edge, completion wins.
- R6: `dout_oe` is high exactly while `cs_n` and `rd_n` are both low. `dout` is 8'h00 whenever `dout_oe` is low.
- R7: The latched result on `dout` stays unchanged until the next completion.
- R8: A comparator that is always high gives 8'hFF (full scale). A comparator that is only high for code 0, meaning an input at or below zero, gives 8'h00.
- R9: With `wr_n` driven from `int_n` and `cs_n` held low, conversions repeat without further host action.
- R10: After reset, `int_n` = 1, `dac_code` = 0, the latch holds 0, and the phase counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low start strobe |
| rd_n | input | 1 | Active-low read strobe |
| cmp_ge | input | 1 | Comparator: input at or above the trial level |
| dac_code | output | 8 | Trial code to the DAC |
| int_n | output | 1 | Active-low conversion-done interrupt |
| dout | output | 8 | Latched result, zero while not enabled |
| dout_oe | output | 1 | Output enable for the tri-state bus pads |

## Verification
The assertions take the strobes to be synchronous to `clk` and stable between edges. They also take `cmp_ge` to be a pure function of the current `dac_code`, and assume no strobe activity falls within the reset cycle. The bench meets these conditions by changing strobes only on falling clock edges. It derives `cmp_ge` combinationally from a stored integer input level compared against `dac_code`. This covers levels below zero, levels above full scale, a restart in mid-search, and free-running operation through a wired-back write strobe.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int unsigned DEF_WIDTH     = 8;
  parameter int unsigned DEF_STEP_CLKS = 8;

  function automatic int unsigned phase_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sar_step_div.sv
module sar_step_div #(
  parameter int unsigned STEP_CLKS = sar_pkg::DEF_STEP_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PH_W = sar_pkg::phase_bits(STEP_CLKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_CLKS - 1);

  generate
    if (STEP_CLKS <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                      phase <= phase + 1'b1;
      end
      assign tick = (phase == PH_LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_start_ctl.sv
module sar_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  output logic go
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)    armed <= 1'b0;
    else if (hold) armed <= 1'b1;
    else if (tick) armed <= 1'b0;
  end

  assign go = armed & tick & ~hold;
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int unsigned WIDTH = sar_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             go,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] acc,
  output logic             last
);
  localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] walk;
  logic [WIDTH-1:0] keep;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_keep
      assign keep[b] = walk[b] & cmp_ge;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      walk <= '0;
      acc  <= '0;
    end else if (go) begin
      walk <= TOP_ONE;
      acc  <= '0;
    end else if (tick && (walk != '0)) begin
      acc  <= acc | keep;
      walk <= walk >> 1;
    end
  end

  assign trial = acc | walk;
  assign last  = tick & walk[0] & ~hold;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int unsigned WIDTH     = sar_pkg::DEF_WIDTH,
  parameter int unsigned STEP_CLKS = sar_pkg::DEF_STEP_CLKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] dac_code,
  output logic             int_n,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe
);
  logic             hold, rd_sel, step_tick, go, last;
  logic             done_q, irq_ff;
  logic [WIDTH-1:0] acc, result_q;

  assign hold   = ~cs_n & ~wr_n;
  assign rd_sel = ~cs_n & ~rd_n;

  sar_step_div #(.STEP_CLKS(STEP_CLKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(step_tick)
  );

  sar_start_ctl u_start (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(step_tick), .go(go)
  );

  sar_search #(.WIDTH(WIDTH)) u_search (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(step_tick), .go(go),
    .cmp_ge(cmp_ge), .trial(dac_code), .acc(acc), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      irq_ff   <= 1'b0;
      result_q <= '0;
    end else if (hold) begin
      done_q <= 1'b0;
      irq_ff <= 1'b0;
    end else begin
      done_q <= last;
      if (done_q) begin
        result_q <= acc;
        irq_ff   <= 1'b1;
      end else if (rd_sel) begin
        irq_ff <= 1'b0;
      end
    end
  end

  assign int_n   = ~irq_ff;
  assign dout_oe = rd_sel;
  assign dout    = rd_sel ? result_q : '0;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             wr_n,
  input logic             rd_n,
  input logic [WIDTH-1:0] dac_code,
  input logic             int_n,
  input logic [WIDTH-1:0] dout,
  input logic             dout_oe,
  input logic             step_tick
);
  a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n) |=> (int_n && dac_code == '0));

  a_r3_code_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> ($past(step_tick) || $past(!cs_n && !wr_n)));

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && cs_n) |=> !int_n);

  a_r6_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && !$fell(int_n)) |-> $stable(dout));
endmodule

bind sar_seq_top sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
  .dac_code(dac_code), .int_n(int_n), .dout(dout), .dout_oe(dout_oe),
  .step_tick(step_tick)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1;
  logic       free_run = 1'b0;
  logic       wr_n, cmp_ge, int_n, dout_oe;
  logic [7:0] dac_code, dout;
  int         vin = 0;
  int         checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  assign wr_n   = free_run ? (int_n & wr_drv) : wr_drv;
  assign cmp_ge = (vin >= int'(dac_code));

  sar_seq_top i_sar_seq_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .int_n(int_n), .dout(dout),
    .dout_oe(dout_oe)
  );

  // behavioural reference
  int m_ph, m_bit, m_acc, m_latch;
  bit m_start, m_done, m_irq;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit hold, tick, done_n;
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_bit = -1; m_acc = 0; m_latch = 0;
      m_start = 0; m_done = 0; m_irq = 0;
    end else begin
      hold = !cs_n && !wr_n;
      tick = (m_ph == 7);
      done_n = 0;
      if (hold) begin
        m_start = 1; m_bit = -1; m_acc = 0; m_done = 0; m_irq = 0;
      end else begin
        if (m_done) begin m_latch = m_acc; m_irq = 1; end
        else if (!cs_n && !rd_n) m_irq = 0;
        if (tick) begin
          if (m_start) begin m_start = 0; m_bit = 7; m_acc = 0; end
          else if (m_bit >= 0) begin
            if (vin >= (m_acc | (1 << m_bit))) m_acc = m_acc | (1 << m_bit);
            if (m_bit == 0) done_n = 1;
            m_bit--;
          end
        end
        m_done = done_n;
      end
      m_ph = (m_ph + 1) % 8;
    end
  end

  always @(negedge clk) begin
    int exp_dac, exp_out;
    bit exp_oe;
    if (rst_n) begin
      exp_dac = m_acc | ((m_bit >= 0) ? (1 << m_bit) : 0);
      exp_oe  = !cs_n && !rd_n;
      exp_out = exp_oe ? m_latch : 0;
      chk(int'(dac_code) == exp_dac, "R3 dac_code", dac_code, exp_dac);
      chk(int_n == !m_irq, "R5 int_n", int_n, !m_irq);
      chk(dout_oe == exp_oe, "R6 dout_oe", dout_oe, exp_oe);
      chk(int'(dout) == exp_out, "R7 dout", dout, exp_out);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R4 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic read_check(input int exp, input string req);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(dout_oe == 1'b1, "R6 enable during read", dout_oe, 1);
    chk(int'(dout) == exp, req, dout, exp);
    @(negedge clk);
    chk(int_n == 1'b1, "R5 read clears int_n", int_n, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_conv(input int v, input bit expect_done, input string req);
    int lat, span;
    vin = v;
    cs_n = 1'b0; wr_drv = 1'b0;
    repeat (3) @(negedge clk);
    chk(int_n == 1'b1 && dac_code == 8'h00, "R1 hold state", dac_code, 0);
    cs_n = 1'b1; wr_drv = 1'b1;
    lat = 0;
    while (dac_code != 8'h80 && lat < 20) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= 8, "R2 start latency", lat, 8);
    if (expect_done) begin
      span = 0;
      while (int_n && span < 200) begin @(negedge clk); span++; end
      chk(span == 65, "R4 search length", span, 65);
      chk(int_n == 1'b0, "R4 int_n low at completion", int_n, 0);
      repeat (5) @(negedge clk);
      chk(int_n == 1'b0, "R5 int_n stays low", int_n, 0);
      read_check(clamp(v), req);
      read_check(clamp(v), "R7 result held");
    end
  endtask

  initial begin
    int falls;
    bit prev;
    repeat (2) @(negedge clk);
    chk(int_n == 1'b1 && dac_code == 8'h00 && dout == 8'h00, "R10 reset state", int_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    do_conv(100, 1, "R3 code for 100");
    do_conv(300, 1, "R8 full scale");
    do_conv(-5, 1, "R8 negative input");
    do_conv(0, 1, "R8 zero input");
    do_conv(1, 1, "R3 code for 1");
    do_conv(170, 1, "R3 code for 170");
    do_conv(200, 0, "R1 abort");
    repeat (20) @(negedge clk);
    do_conv(33, 1, "R1 restart result");
    // R9 free running
    vin = 77; free_run = 1'b1; cs_n = 1'b0;
    wr_drv = 1'b0; @(negedge clk); wr_drv = 1'b1;
    falls = 0; prev = int_n;
    repeat (300) begin
      @(negedge clk);
      if (prev && !int_n) falls++;
      prev = int_n;
    end
    chk(falls >= 3, "R9 free-running conversions", falls, 3);
    cs_n = 1'b1; free_run = 1'b0;
    repeat (3) @(negedge clk);
    read_check(77, "R9 free-running result");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule